// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This block watches one asynchronous input pin. It records the value of an external free-running timer when that pin changes level. A rising change of the effective level stores the timer value in one register, and a falling change stores it in a second register. The effective level is the pin after an optional inversion. Each direction also sets its own sticky flag. A flag stays set until a one-cycle clear strobe for that direction arrives.

A single interrupt line combines both flags. Each flag passes to that line only when its own enable input is high. A global capture enable gates the whole unit. While the enable is low, no value is stored and no flag is set. The edge history keeps following the pin during that time, so turning capture back on does not create an edge. The pin first passes through a two-stage synchronizer. A stored value is therefore the timer count present at the third rising clock edge after the pin changes.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, both capture registers read 0, both flags read 0 and `irq_o` is 0.
- R2: With `invert_i`=0 and `cap_en_i`=1, a 0-to-1 change of `pin_i` stores `count_i` in `rise_val_o` and sets `rise_flag_o`. The stored count is the one present at the third rising clock edge after the pin change.
- R3: With `invert_i`=0 and `cap_en_i`=1, a 1-to-0 change of `pin_i` stores `count_i` in `fall_val_o` and sets `fall_flag_o`, with the same latency as R2.
- R4: With `invert_i`=1, a 0-to-1 change of the pin counts as a falling event and a 1-to-0 change counts as a rising event.
- R5: While `cap_en_i`=0, neither capture register nor either flag is set or changed by pin activity. Pin changes made while disabled produce no event once `cap_en_i` returns to 1.
- R6: `irq_o` equals (`rise_flag_o` AND `rise_ie_i`) OR (`fall_flag_o` AND `fall_ie_i`), with no added delay.
- R7: A one-cycle `rise_clr_i` or `fall_clr_i` strobe clears that flag at the next clock edge. An event of the same direction at the same edge leaves the flag set.
- R8: The two directions are independent. Clearing one flag or storing one register leaves the other direction's flag and value unchanged. A register holds its value until the next event of its own direction.
- R9: Changing `invert_i` while the pin is steady produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous input pin |
| count_i | input | CNT_W | Free-running timer value to be stored |
| cap_en_i | input | 1 | Capture enable |
| invert_i | input | 1 | Invert the pin before edge detection |
| rise_ie_i | input | 1 | Rising-event interrupt enable |
| fall_ie_i | input | 1 | Falling-event interrupt enable |
| rise_clr_i | input | 1 | Write-one clear strobe for the rising flag |
| fall_clr_i | input | 1 | Write-one clear strobe for the falling flag |
| rise_val_o | output | CNT_W | Timer value stored at the last rising event |
| fall_val_o | output | CNT_W | Timer value stored at the last falling event |
| rise_flag_o | output | 1 | Sticky rising-event flag |
| fall_flag_o | output | 1 | Sticky falling-event flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that `count_i`, the enables and the clear strobes are synchronous to `clk` and stable around its rising edge. Only `pin_i` may change at any time. The bench drives every input on the falling clock edge, so all of them meet that assumption. The pin is held for random spans, both single-cycle pulses and long levels. This exercises events that arrive close together without relying on any minimum pulse width.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cap_en_i,
  input  logic             invert_i,
  input  logic             rise_ie_i,
  input  logic             fall_ie_i,
  input  logic             rise_clr_i,
  input  logic             fall_clr_i,
  output logic [CNT_W-1:0] rise_val_o,
  output logic [CNT_W-1:0] fall_val_o,
  output logic             rise_flag_o,
  output logic             fall_flag_o,
  output logic             irq_o
);

  localparam int LAST = SYNC_LEN - 1;

  logic [SYNC_LEN-1:0] sync_q;
  logic                prev_q;
  logic                lvl, raw_up, raw_dn, rise_evt, fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], pin_i};
      prev_q <= lvl;
    end
  end

  assign lvl      = sync_q[LAST];
  assign raw_up   = lvl & ~prev_q;
  assign raw_dn   = ~lvl & prev_q;
  assign rise_evt = cap_en_i & (invert_i ? raw_dn : raw_up);
  assign fall_evt = cap_en_i & (invert_i ? raw_up : raw_dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_val_o  <= '0;
      fall_val_o  <= '0;
      rise_flag_o <= 1'b0;
      fall_flag_o <= 1'b0;
    end else begin
      if (rise_evt) begin
        rise_val_o  <= count_i;
        rise_flag_o <= 1'b1;
      end else if (rise_clr_i) begin
        rise_flag_o <= 1'b0;
      end
      if (fall_evt) begin
        fall_val_o  <= count_i;
        fall_flag_o <= 1'b1;
      end else if (fall_clr_i) begin
        fall_flag_o <= 1'b0;
      end
    end
  end

  assign irq_o = (rise_flag_o & rise_ie_i) | (fall_flag_o & fall_ie_i);

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_flag_o) |-> $past(cap_en_i)); // R2
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fall_flag_o) |-> $past(cap_en_i)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> ($stable(rise_val_o) && $stable(fall_val_o))); // R5
  AST_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_clr_i && !cap_en_i) |=> !rise_flag_o); // R7
  AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_clr_i && !cap_en_i) |=> !fall_flag_o); // R7
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rise_flag_o || fall_flag_o)); // R6
  AST_RVAL_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rise_val_o) |-> rise_flag_o); // R8
  AST_FVAL_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fall_val_o) |-> fall_flag_o); // R8

endmodule

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, en = 1'b0, inv = 1'b0, rie = 1'b0, fie = 1'b0, rclr = 1'b0, fclr = 1'b0;
  logic [15:0] cnt = 16'd0;
  logic [15:0] rval, fval;
  logic rflag, fflag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(cnt), .cap_en_i(en),
    .invert_i(inv), .rise_ie_i(rie), .fall_ie_i(fie), .rise_clr_i(rclr),
    .fall_clr_i(fclr), .rise_val_o(rval), .fall_val_o(fval),
    .rise_flag_o(rflag), .fall_flag_o(fflag), .irq_o(irq));

  // behavioural reference: pin history queue, previous level, stored values
  bit q_pin[$];
  bit m_prev;
  int m_rv, m_fv;
  bit m_rf, m_ff;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_pin.delete(); q_pin.push_back(1'b0); q_pin.push_back(1'b0);
      m_prev = 0; m_rv = 0; m_fv = 0; m_rf = 0; m_ff = 0;
    end else begin
      bit cur, up, dn;
      cur = q_pin[0];
      up = en && ((!inv && cur && !m_prev) || (inv && !cur && m_prev));
      dn = en && ((!inv && !cur && m_prev) || (inv && cur && !m_prev));
      if (up) begin m_rv = cnt; m_rf = 1; end else if (rclr) m_rf = 0;
      if (dn) begin m_fv = cnt; m_ff = 1; end else if (fclr) m_ff = 0;
      m_prev = cur;
      void'(q_pin.pop_front());
      q_pin.push_back(pin);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk("R2 rise value", rval, m_rv);
      chk("R3 fall value", fval, m_fv);
      chk("R7 rise flag", rflag, m_rf);
      chk("R7 fall flag", fflag, m_ff);
      chk("R6 irq", irq, (m_rf && rie) || (m_ff && fie));
    end
    cnt = cnt + 16'd1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset values", rval + fval, 0);
    chk("R1 reset flags", rflag + fflag + irq, 0);

    en = 1; rie = 1; fie = 1;
    repeat (4) step();
    pin = 1; c0 = cnt;
    repeat (3) step();
    chk("R2 rise capture count", rval, 32'(c0 + 16'd2));
    chk("R2 rise flag set", rflag, 1);
    chk("R8 fall untouched", fflag, 0);

    repeat (3) step();
    pin = 0; c0 = cnt;
    repeat (3) step();
    chk("R3 fall capture count", fval, 32'(c0 + 16'd2));
    chk("R3 fall flag set", fflag, 1);

    rclr = 1; step(); rclr = 0; step();
    chk("R7 rise cleared", rflag, 0);
    chk("R8 fall flag kept", fflag, 1);
    fie = 0; step();
    chk("R6 irq masked", irq, 0);
    fclr = 1; step(); fclr = 0; fie = 1; step();

    inv = 1; repeat (4) step();
    chk("R9 invert toggle no event", rflag + fflag, 0);
    pin = 1; c0 = cnt;
    repeat (3) step();
    chk("R4 inverted rise to fall reg", fval, 32'(c0 + 16'd2));
    chk("R4 inverted rise no rise flag", rflag, 0);
    inv = 0; repeat (4) step();
    chk("R9 invert back no event", rflag, 0);

    fclr = 1; step(); fclr = 0;
    en = 0;
    pin = 0; repeat (5) step();
    pin = 1; repeat (5) step();
    pin = 0; repeat (5) step();
    chk("R5 disabled no flags", rflag + fflag, 0);
    en = 1; repeat (5) step();
    chk("R5 re-enable no false edge", rflag + fflag, 0);

    // R7 collision: clear strobe coincides with the capturing edge
    pin = 1; c0 = cnt; step(); step();
    rclr = 1; step(); rclr = 0;
    chk("R7 event beats clear", rflag, 1);
    chk("R7 collision value", rval, 32'(c0 + 16'd2));

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) pin = ~pin;
      if (r[4:3] == 2'd0) pin = r[5];
      en = (r[9:6] != 4'd0);
      inv = (r[15:10] == 6'd0) ? ~inv : inv;
      rie = r[16]; fie = r[17];
      rclr = (r[20:18] == 3'd0); fclr = (r[23:21] == 3'd0);
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule